// File: doc/BRIEF.md
# I2C Controller Interrupt Status Unit

This block keeps the interrupt status bits and the interrupt enable bits of a memory-mapped I2C master controller, and it drives a single level-sensitive interrupt line. The transfer engine sets status bits with one-cycle event pulses. Software reads and writes the registers through a simple strobe interface: a word index, write data and read data. The read data is combinational from the addressed register. Read side effects and all writes take effect at the next rising clock edge.

The static parameter `REVISION` picks between two generations of behaviour. When `REVISION` is below 0x34, the block uses the older behaviour. Reading the vector register returns the lowest pending enabled source and also acknowledges it. In this mode the status register cannot be written. When `REVISION` is 0x34 or above, the block uses the newer behaviour. Software clears status bits by writing ones to them, and the vector register does nothing. In this mode the test register can also force the low status bits on.

Register indices used in the requirements are: enable = 1, status = 2, vector = 3, test = 4.

Top module: `i2c_irq_status`

## Requirements
- R1: `irq` is high exactly when some status bit below the enable width is set and its enable bit is also set.
- R2: The enable register (index 1) keeps 5 bits when `REVISION` < 0x34 and 6 bits otherwise. Its other bits read as 0.
- R3: With the older revision, a read of index 3 returns the 1-based position of the lowest set bit of (status AND enable), or 0 if there is none. That read also clears that status bit.
- R4: With the newer revision, a read of index 3 returns 0 and leaves the status unchanged.
- R5: With the newer revision, a write to index 2 clears each status bit 0..5 where the data holds a 1. Status bits above 5 are not affected by the write.
- R6: With the older revision, writes to index 2 have no effect on the status.
- R7: A read of index 2 returns the stored status with bit 12 replaced by the current `bus_busy` input.
- R8: A pulse on `evt_set[i]` sets status bit i. The bit positions are: 1 NACK, 2 access ready, 3 receive ready, 4 transmit ready, 10 transmit underflow. `evt_set[12]` is ignored.
- R9: With the newer revision, a write to index 4 with data bit 11 set forces status bits 0..5 to 1. With the older revision, the same write leaves the status unchanged.
- R10: The test register (index 4) keeps only the data bits in mask 0xF80F.
- R11: When an event sets a bit in the same cycle that a software clear (a status write or a vector acknowledge) clears it, the bit ends up set.
- R12: Reset clears the status, enable and test registers, so `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (triggers read side effects) |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed register |
| evt_set | input | 16 | Status-set event pulses from the transfer engine |
| bus_busy | input | 1 | Current bus-busy indication |
| irq | output | 1 | Level interrupt output |

## Verification
The bench runs both revisions side by side. It drives them with the same stimulus and compares each against its own expectations.

It walks the older vector read through every pending source in turn. A design with the encoder order reversed would return the highest pending source first. A design that forgot the acknowledge would return the same index every time.

It checks that writing the status register with all ones leaves bit 10 set and leaves the older revision untouched. A design with a wide clear mask, or a writable status on the older revision, would lose those bits.

It also lands an event pulse in the same cycle as a clear and as an acknowledge of the same bit. A clear-wins ordering would drop that event.

// File: rtl/irqstat_pkg.sv
package irqstat_pkg;
  localparam int unsigned DATA_W      = 16;
  localparam int unsigned ADDR_W      = 4;
  localparam int unsigned BUSY_BIT    = 12;
  localparam int unsigned FORCE_BIT   = 11;
  localparam int unsigned CLR_W       = 6;
  localparam logic [7:0]  NEW_REV_MIN = 8'h34;
  localparam logic [DATA_W-1:0] TEST_KEEP = 16'hF80F;

  typedef enum logic [ADDR_W-1:0] {
    IDX_ENABLE = 4'd1,
    IDX_STATUS = 4'd2,
    IDX_VECTOR = 4'd3,
    IDX_TEST   = 4'd4
  } reg_idx_e;
endpackage

// File: rtl/irqstat_vec_enc.sv
module irqstat_vec_enc #(
  parameter int unsigned W     = 6,
  localparam int unsigned IDX_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     pend_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [W-1:0]     onehot_o
);
  // scan from the top down so that the lowest pending bit is the one kept
  always_comb begin
    idx_o    = '0;
    onehot_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        idx_o       = IDX_W'(i + 1);
        onehot_o    = '0;
        onehot_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irqstat_ctrl_regs.sv
module irqstat_ctrl_regs
  import irqstat_pkg::*;
#(
  parameter int unsigned EN_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_we,
  input  logic              test_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [EN_W-1:0]   en_o,
  output logic [DATA_W-1:0] test_o
);
  logic [EN_W-1:0]   en_q, en_d;
  logic [DATA_W-1:0] test_q, test_d;

  always_comb begin
    en_d   = wdata[EN_W-1:0];
    test_d = wdata & TEST_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      test_q <= '0;
    end else begin
      if (en_we)   en_q   <= en_d;
      if (test_we) test_q <= test_d;
    end
  end

  assign en_o   = en_q;
  assign test_o = test_q;

  assert_enable_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en_we |=> (en_q == $past(wdata[EN_W-1:0])));

  assert_test_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (test_q & ~TEST_KEEP) == '0);
endmodule

// File: rtl/irqstat_status_reg.sv
module irqstat_status_reg
  import irqstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] set_i,
  input  logic [DATA_W-1:0] clr_i,
  output logic [DATA_W-1:0] stat_o
);
  localparam logic [DATA_W-1:0] KEEP = ~(DATA_W'(1) << BUSY_BIT);

  logic [DATA_W-1:0] stat_q, stat_d, set_eff;
  logic              stat_en;

  always_comb begin
    set_eff = set_i & KEEP;
    stat_en = (|set_eff) | (|clr_i);
    // set is applied after clear: an event in the same cycle wins
    stat_d  = ((stat_q & ~clr_i) | set_eff) & KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  assign stat_o = stat_q;

  assert_set_sticks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_eff) |=> ((stat_q & $past(set_eff)) == $past(set_eff)));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_eff == '0) && (clr_i == '0)) |=> (stat_q == $past(stat_q)));
endmodule

// File: rtl/i2c_irq_status.sv
module i2c_irq_status
  import irqstat_pkg::*;
#(
  parameter logic [7:0] REVISION = 8'h34
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [DATA_W-1:0] evt_set,
  input  logic              bus_busy,
  output logic              irq
);
  localparam bit          NEW_REV = (REVISION >= NEW_REV_MIN);
  localparam int unsigned EN_W    = NEW_REV ? 6 : 5;
  localparam int unsigned IDX_W   = $clog2(EN_W + 1);

  logic              hit_en, hit_stat, hit_vec, hit_test;
  logic [EN_W-1:0]   en, pend, ack_oh;
  logic [IDX_W-1:0]  vec_idx;
  logic [DATA_W-1:0] test_q, stat, set_v, clr_v, stat_view;

  always_comb begin
    hit_en   = (reg_addr == IDX_ENABLE);
    hit_stat = (reg_addr == IDX_STATUS);
    hit_vec  = (reg_addr == IDX_VECTOR);
    hit_test = (reg_addr == IDX_TEST);
  end

  irqstat_ctrl_regs #(.EN_W(EN_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_we   (reg_wr && hit_en),
    .test_we (reg_wr && hit_test),
    .wdata   (reg_wdata),
    .en_o    (en),
    .test_o  (test_q)
  );

  assign pend = stat[EN_W-1:0] & en;

  irqstat_vec_enc #(.W(EN_W)) u_enc (
    .pend_i   (pend),
    .idx_o    (vec_idx),
    .onehot_o (ack_oh)
  );

  generate
    if (NEW_REV) begin : g_new
      always_comb begin
        clr_v = '0;
        set_v = evt_set;
        if (reg_wr && hit_stat)
          clr_v = {{(DATA_W-CLR_W){1'b0}}, reg_wdata[CLR_W-1:0]};
        if (reg_wr && hit_test && reg_wdata[FORCE_BIT])
          set_v = evt_set | {{(DATA_W-CLR_W){1'b0}}, {CLR_W{1'b1}}};
      end

      assert_vector_inert_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && hit_vec && (evt_set == '0)) |=> (stat == $past(stat)));

      assert_force_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && hit_test && reg_wdata[FORCE_BIT]) |=> (stat[CLR_W-1:0] == {CLR_W{1'b1}}));
    end else begin : g_old
      always_comb begin
        set_v = evt_set;
        clr_v = '0;
        if (reg_rd && hit_vec)
          clr_v = {{(DATA_W-EN_W){1'b0}}, ack_oh};
      end

      assert_ack_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_v));

      assert_status_ro_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && hit_stat && (evt_set == '0)) |=> (stat == $past(stat)));
    end
  endgenerate

  irqstat_status_reg u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_v),
    .clr_i  (clr_v),
    .stat_o (stat)
  );

  always_comb begin
    stat_view           = stat;
    stat_view[BUSY_BIT] = bus_busy;
  end

  always_comb begin
    reg_rdata = '0;
    if (hit_en)        reg_rdata = {{(DATA_W-EN_W){1'b0}}, en};
    else if (hit_stat) reg_rdata = stat_view;
    else if (hit_vec)  reg_rdata = NEW_REV ? '0 : {{(DATA_W-IDX_W){1'b0}}, vec_idx};
    else if (hit_test) reg_rdata = test_q;
  end

  assign irq = |pend;

  assert_irq_needs_status_R1: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat != '0) && (en != '0));
endmodule

// File: tb/i2c_irq_status_tb_top.sv
`timescale 1ns/1ps
module i2c_irq_status_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd, bus_busy;
  logic [3:0]  reg_addr;
  logic [15:0] reg_wdata, evt_set;
  logic [15:0] rdata_n, rdata_o;
  logic        irq_n, irq_o;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  i2c_irq_status #(.REVISION(8'h34)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_n), .evt_set(evt_set),
    .bus_busy(bus_busy), .irq(irq_n));

  i2c_irq_status #(.REVISION(8'h11)) dut_old_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_o), .evt_set(evt_set),
    .bus_busy(bus_busy), .irq(irq_o));

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d, logic [15:0] ev = 16'h0);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; evt_set = ev;
    @(negedge clk);
    reg_wr = 1'b0; evt_set = 16'h0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] vn, output logic [15:0] vo,
                    input logic [15:0] ev = 16'h0);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a; evt_set = ev;
    #1 vn = rdata_n; vo = rdata_o;
    @(negedge clk);
    reg_rd = 1'b0; evt_set = 16'h0;
  endtask

  task automatic pulse(logic [15:0] ev);
    @(negedge clk);
    evt_set = ev;
    @(negedge clk);
    evt_set = 16'h0;
  endtask

  task automatic t_reset();
    logic [15:0] vn, vo;
    check("R12 irq new", {15'h0, irq_n}, 16'h0);
    check("R12 irq old", {15'h0, irq_o}, 16'h0);
    rd(4'd2, vn, vo); check("R12 status new", vn, 16'h0); check("R12 status old", vo, 16'h0);
    rd(4'd1, vn, vo); check("R12 enable new", vn, 16'h0); check("R12 enable old", vo, 16'h0);
    rd(4'd4, vn, vo); check("R12 test new", vn, 16'h0);
  endtask

  task automatic t_enable_width();
    logic [15:0] vn, vo;
    wr(4'd1, 16'hFFFF);
    rd(4'd1, vn, vo);
    check("R2 enable new", vn, 16'h003F);
    check("R2 enable old", vo, 16'h001F);
    wr(4'd1, 16'h0000);
  endtask

  task automatic t_events();
    logic [15:0] vn, vo;
    pulse(16'h1002); pulse(16'h0004); pulse(16'h0008); pulse(16'h0010); pulse(16'h0400);
    rd(4'd2, vn, vo);
    check("R8 status new", vn, 16'h041E);
    check("R8 status old", vo, 16'h041E);
    #1 check("R1 irq off with enable 0", {15'h0, irq_n}, 16'h0);
    wr(4'd1, 16'h0004);
    #1 check("R1 irq new", {15'h0, irq_n}, 16'h1);
    check("R1 irq old", {15'h0, irq_o}, 16'h1);
    wr(4'd1, 16'h0020);
    #1 check("R1 irq new unmatched", {15'h0, irq_n}, 16'h0);
  endtask

  task automatic t_busy();
    logic [15:0] vn, vo;
    bus_busy = 1'b1;
    rd(4'd2, vn, vo);
    check("R7 busy new", vn, 16'h141E);
    check("R7 busy old", vo, 16'h141E);
    bus_busy = 1'b0;
  endtask

  task automatic t_vector();
    logic [15:0] vn, vo;
    wr(4'd1, 16'h003F);
    rd(4'd3, vn, vo); check("R3 vec old 1st", vo, 16'd2); check("R4 vec new", vn, 16'd0);
    rd(4'd3, vn, vo); check("R3 vec old 2nd", vo, 16'd3);
    rd(4'd3, vn, vo); check("R3 vec old 3rd", vo, 16'd4);
    rd(4'd3, vn, vo); check("R3 vec old 4th", vo, 16'd5);
    rd(4'd3, vn, vo); check("R3 vec old empty", vo, 16'd0);
    rd(4'd2, vn, vo);
    check("R3 status old after acks", vo, 16'h0400);
    check("R4 status new unchanged", vn, 16'h041E);
    #1 check("R3 irq old cleared", {15'h0, irq_o}, 16'h0);
  endtask

  task automatic t_force();
    logic [15:0] vn, vo;
    wr(4'd4, 16'h0800);
    rd(4'd2, vn, vo);
    check("R9 force new", vn, 16'h043F);
    check("R9 no force old", vo, 16'h0400);
    wr(4'd4, 16'h0000);
  endtask

  task automatic t_status_write();
    logic [15:0] vn, vo;
    pulse(16'h0006);
    wr(4'd2, 16'h0005);
    rd(4'd2, vn, vo);
    check("R5 partial clear new", vn, 16'h043A);
    check("R6 status ro old", vo, 16'h0406);
    wr(4'd2, 16'hFFFF);
    rd(4'd2, vn, vo);
    check("R5 full clear keeps bit10", vn, 16'h0400);
    check("R6 status ro old all ones", vo, 16'h0406);
    #1 check("R1 irq new after clear", {15'h0, irq_n}, 16'h0);
  endtask

  task automatic t_test_mask();
    logic [15:0] vn, vo;
    wr(4'd4, 16'hFFFF);
    rd(4'd4, vn, vo);
    check("R10 test new", vn, 16'hF80F);
    check("R10 test old", vo, 16'hF80F);
    rd(4'd2, vn, vo);
    check("R9 force via full write", vn, 16'h043F);
    wr(4'd4, 16'h0000);
  endtask

  task automatic t_set_wins();
    logic [15:0] vn, vo;
    wr(4'd2, 16'h0003, 16'h0002);
    rd(4'd2, vn, vo);
    check("R11 set beats write clear", vn, 16'h043E);
    rd(4'd3, vn, vo, 16'h0002);
    check("R11 vec old value", vo, 16'd2);
    rd(4'd2, vn, vo);
    check("R11 set beats ack", vo, 16'h0406);
  endtask

  task automatic t_reset_mid();
    logic [15:0] vn, vo;
    @(negedge clk); rst_n = 1'b0;
    #1 check("R12 irq new in reset", {15'h0, irq_n}, 16'h0);
    check("R12 irq old in reset", {15'h0, irq_o}, 16'h0);
    @(negedge clk); rst_n = 1'b1;
    rd(4'd2, vn, vo); check("R12 status after reset", vn | vo, 16'h0);
    rd(4'd1, vn, vo); check("R12 enable after reset", vn | vo, 16'h0);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = 4'd0;
    reg_wdata = 16'h0; evt_set = 16'h0; bus_busy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enable_width();
    t_events();
    t_busy();
    t_vector();
    t_force();
    t_status_write();
    t_test_mask();
    t_set_wins();
    t_reset_mid();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule